// File: doc/BRIEF.md
# Halfword-Granular Instruction Fetch Sequencer

This block fetches one instruction for a core that may accept 16-bit compressed encodings. A single-cycle start hands it a program counter. The block asks an optional address hook whether the granule may be fetched, and checks alignment. It then translates the address and reads memory one 16-bit halfword at a time. Both the translation unit and the memory sit behind valid/ready request ports, and each port returns one response beat per accepted request.

When the first halfword is compressed, the fetch stops at that point. Otherwise the block computes the second granule address, PC+2, which wraps at the register width. It sends that address through the hook again, translates it on its own and reads it. Each result ends with a one-cycle done pulse that carries a result kind, the instruction, and a cause and faulting address. The faulting address is always the untransformed address of the granule that failed.

The sequencer walks the states IDLE, CHECK, XLATE_LO, READ_LO, XLATE_HI, READ_HI and DONE:

- IDLE moves to CHECK on start.
- CHECK moves to DONE on a hook rejection or a misalignment. Otherwise it moves to XLATE_LO.
- XLATE_LO moves to READ_LO on a good translation, or to DONE on a fault.
- READ_LO moves to DONE on an access error or a compressed halfword, and to DONE on a hook rejection of PC+2. Otherwise it moves to XLATE_HI.
- XLATE_HI moves to READ_HI, or to DONE on a fault.
- READ_HI always moves to DONE.
- DONE returns to IDLE.

Top module: `ifetch_seq`

## Requirements
- R1: After reset the block is idle: done_o is 0 and neither xl_req_valid_o nor mem_req_valid_o is asserted.
- R2: If the address that the hook hands back for the first granule has bit 0 set, the fetch ends with kind 2 (fault), cause 0 and the fault address PC. The same happens if bit 1 is set while rvc_en_i was 0 at start. No translation request is issued in either case.
- R3: A translation fault on the first granule ends the fetch with kind 2, the cause given by the translation unit, and the fault address PC.
- R4: A memory error on the first halfword read ends the fetch with kind 2, cause 1 and the fault address PC.
- R5: A halfword whose bits 1:0 are not 2'b11 is compressed. If the first halfword is compressed, the fetch ends with kind 0 and instr_o = {16'h0, halfword}, after exactly one translation and one memory read.
- R6: Otherwise the block forms PC+2 modulo 2^XLEN, translates it separately and reads it. The fetch then ends with kind 1 and instr_o = {second halfword, first halfword}, after two translations and two reads.
- R7: A translation fault or memory error on the second granule reports the fault address PC+2, with the translation cause or with cause 1 respectively.
- R8: The hook sees hook_pc_o = PC in CHECK and PC+2 otherwise. If it rejects a granule, the fetch ends with kind 3, the hook's error code and that granule's untransformed address. If it accepts, the address it returns is the one that gets translated, and any fault still reports PC or PC+2.
- R9: A request stays asserted with a stable address until ready is seen. The two ports never request in the same cycle, and response latency may be any number of cycles.
- R10: start_i is ignored unless the block is idle, and done_o lasts exactly one cycle per fetch.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Begin a fetch (taken only when idle) |
| pc_i | input | XLEN | Program counter to fetch |
| rvc_en_i | input | 1 | Compressed encodings enabled |
| hook_pc_o | output | XLEN | Untransformed granule address offered to the hook |
| hook_ok_i | input | 1 | Hook accepts the granule |
| hook_use_i | input | XLEN | Address to use for the granule when accepted |
| hook_err_i | input | CW | Hook error code on rejection |
| xl_req_valid_o | output | 1 | Translation request valid |
| xl_req_ready_i | input | 1 | Translation request accepted |
| xl_req_va_o | output | XLEN | Virtual address to translate |
| xl_rsp_valid_i | input | 1 | Translation response valid |
| xl_rsp_fault_i | input | 1 | Translation failed |
| xl_rsp_cause_i | input | CW | Fault cause from translation |
| xl_rsp_pa_i | input | PAW | Translated physical address |
| mem_req_valid_o | output | 1 | Halfword read request valid |
| mem_req_ready_i | input | 1 | Read request accepted |
| mem_req_addr_o | output | PAW | Physical address of the 2-byte read |
| mem_rsp_valid_i | input | 1 | Read response valid |
| mem_rsp_err_i | input | 1 | Read access error |
| mem_rsp_data_i | input | 16 | Halfword read data |
| done_o | output | 1 | One-cycle result strobe |
| kind_o | output | 2 | 0 compressed, 1 full, 2 fault, 3 hook error |
| instr_o | output | 32 | Fetched instruction |
| cause_o | output | CW | Fault or hook error code |
| fault_addr_o | output | XLEN | Untransformed faulting address |

## Verification
The bench sends a granule pair across the top of the address space. A design without proper wraparound would translate a wrong second address and return wrong upper bits. Separate faults on the lower and upper granules check that PC+2, not PC, is reported. A sequencer that shared one fault address would fail there. Cases with a hook rejection and a hook substitution catch a design that reports the substituted address, or that skips the hook for the second granule. Compressed halfwords at PC with bit 1 set, and the request counts, expose a design that reads PC+2 it has no need of. A start pulse in the middle of a fetch exposes one that restarts while busy.

// File: rtl/ifetch_pkg.sv
package ifetch_pkg;

    typedef enum logic [2:0] {
        S_IDLE,
        S_CHECK,
        S_XLATE_LO,
        S_READ_LO,
        S_XLATE_HI,
        S_READ_HI,
        S_DONE
    } fetch_state_e;

    typedef enum logic [1:0] {
        RK_COMP  = 2'd0,
        RK_FULL  = 2'd1,
        RK_FAULT = 2'd2,
        RK_HOOK  = 2'd3
    } res_kind_e;

    localparam logic [3:0] CAUSE_MISALIGN = 4'd0;
    localparam logic [3:0] CAUSE_ACCESS   = 4'd1;

    // A halfword opens a compressed encoding unless its low two bits are both set.
    function automatic logic is_compressed(input logic [15:0] hw);
        return hw[1:0] != 2'b11;
    endfunction

endpackage

// File: rtl/ifetch_align_chk.sv
module ifetch_align_chk (
    input  logic [1:0] addr_lo_i,
    input  logic       rvc_en_i,
    output logic       misaligned_o
);
    // Odd addresses never work; halfword-aligned ones need compressed support.
    assign misaligned_o = addr_lo_i[0] | (addr_lo_i[1] & ~rvc_en_i);
endmodule

// File: rtl/ifetch_hook.sv
module ifetch_hook #(
    parameter int XLEN    = 32,
    parameter int CW      = 4,
    parameter int HOOK_EN = 1
) (
    input  logic [XLEN-1:0] pc_i,
    input  logic            ok_i,
    input  logic [XLEN-1:0] use_i,
    input  logic [CW-1:0]   err_i,
    output logic            ok_o,
    output logic [XLEN-1:0] use_o,
    output logic [CW-1:0]   err_o
);
    generate
        if (HOOK_EN != 0) begin : g_hook
            assign ok_o  = ok_i;
            assign use_o = ok_i ? use_i : pc_i;
            assign err_o = err_i;
        end else begin : g_pass
            assign ok_o  = 1'b1;
            assign use_o = pc_i;
            assign err_o = '0;
        end
    endgenerate
endmodule

// File: rtl/ifetch_seq.sv
module ifetch_seq
    import ifetch_pkg::*;
#(
    parameter int XLEN    = 32,
    parameter int PAW     = 32,
    parameter int CW      = 4,
    parameter int HOOK_EN = 1
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            start_i,
    input  logic [XLEN-1:0] pc_i,
    input  logic            rvc_en_i,
    output logic [XLEN-1:0] hook_pc_o,
    input  logic            hook_ok_i,
    input  logic [XLEN-1:0] hook_use_i,
    input  logic [CW-1:0]   hook_err_i,
    output logic            xl_req_valid_o,
    input  logic            xl_req_ready_i,
    output logic [XLEN-1:0] xl_req_va_o,
    input  logic            xl_rsp_valid_i,
    input  logic            xl_rsp_fault_i,
    input  logic [CW-1:0]   xl_rsp_cause_i,
    input  logic [PAW-1:0]  xl_rsp_pa_i,
    output logic            mem_req_valid_o,
    input  logic            mem_req_ready_i,
    output logic [PAW-1:0]  mem_req_addr_o,
    input  logic            mem_rsp_valid_i,
    input  logic            mem_rsp_err_i,
    input  logic [15:0]     mem_rsp_data_i,
    output logic            done_o,
    output logic [1:0]      kind_o,
    output logic [31:0]     instr_o,
    output logic [CW-1:0]   cause_o,
    output logic [XLEN-1:0] fault_addr_o
);
    localparam int HW = 16;
    localparam int IW = 2 * HW;

    fetch_state_e    state_q, state_d;
    res_kind_e       kind_q, kind_d;
    logic [XLEN-1:0] pc_q, pc_d, va_q, va_d, faddr_q, faddr_d, pc_hi;
    logic [PAW-1:0]  pa_q, pa_d;
    logic [HW-1:0]   lo_q, lo_d;
    logic [IW-1:0]   instr_q, instr_d;
    logic [CW-1:0]   cause_q, cause_d;
    logic            rvc_q, rvc_d, sent_q, sent_d;
    logic            h_ok, mis;
    logic [XLEN-1:0] h_use;
    logic [CW-1:0]   h_err;

    assign pc_hi     = pc_q + XLEN'(2);
    assign hook_pc_o = (state_q == S_CHECK) ? pc_q : pc_hi;

    ifetch_hook #(.XLEN(XLEN), .CW(CW), .HOOK_EN(HOOK_EN)) u_hook (
        .pc_i  (hook_pc_o),
        .ok_i  (hook_ok_i),
        .use_i (hook_use_i),
        .err_i (hook_err_i),
        .ok_o  (h_ok),
        .use_o (h_use),
        .err_o (h_err)
    );

    ifetch_align_chk u_align (
        .addr_lo_i    (h_use[1:0]),
        .rvc_en_i     (rvc_q),
        .misaligned_o (mis)
    );

    // State register and datapath registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= S_IDLE;
            kind_q  <= RK_COMP;
            pc_q    <= '0;
            va_q    <= '0;
            pa_q    <= '0;
            lo_q    <= '0;
            instr_q <= '0;
            cause_q <= '0;
            faddr_q <= '0;
            rvc_q   <= 1'b0;
            sent_q  <= 1'b0;
        end else begin
            state_q <= state_d;
            kind_q  <= kind_d;
            pc_q    <= pc_d;
            va_q    <= va_d;
            pa_q    <= pa_d;
            lo_q    <= lo_d;
            instr_q <= instr_d;
            cause_q <= cause_d;
            faddr_q <= faddr_d;
            rvc_q   <= rvc_d;
            sent_q  <= sent_d;
        end
    end

    // Transitions
    always_comb begin
        state_d = state_q;
        kind_d  = kind_q;
        pc_d    = pc_q;
        va_d    = va_q;
        pa_d    = pa_q;
        lo_d    = lo_q;
        instr_d = instr_q;
        cause_d = cause_q;
        faddr_d = faddr_q;
        rvc_d   = rvc_q;
        sent_d  = sent_q;
        unique case (state_q)
            S_IDLE: begin
                sent_d = 1'b0;
                if (start_i) begin
                    pc_d    = pc_i;
                    rvc_d   = rvc_en_i;
                    state_d = S_CHECK;
                end
            end
            S_CHECK: begin
                instr_d = '0;
                faddr_d = pc_q;
                if (!h_ok) begin
                    kind_d  = RK_HOOK;
                    cause_d = h_err;
                    state_d = S_DONE;
                end else if (mis) begin
                    kind_d  = RK_FAULT;
                    cause_d = CW'(CAUSE_MISALIGN);
                    state_d = S_DONE;
                end else begin
                    va_d    = h_use;
                    state_d = S_XLATE_LO;
                end
            end
            S_XLATE_LO, S_XLATE_HI: begin
                if (!sent_q) begin
                    sent_d = xl_req_ready_i;
                end else if (xl_rsp_valid_i) begin
                    sent_d = 1'b0;
                    if (xl_rsp_fault_i) begin
                        kind_d  = RK_FAULT;
                        cause_d = xl_rsp_cause_i;
                        faddr_d = (state_q == S_XLATE_LO) ? pc_q : pc_hi;
                        state_d = S_DONE;
                    end else begin
                        pa_d    = xl_rsp_pa_i;
                        state_d = (state_q == S_XLATE_LO) ? S_READ_LO : S_READ_HI;
                    end
                end
            end
            S_READ_LO: begin
                if (!sent_q) begin
                    sent_d = mem_req_ready_i;
                end else if (mem_rsp_valid_i) begin
                    sent_d = 1'b0;
                    if (mem_rsp_err_i) begin
                        kind_d  = RK_FAULT;
                        cause_d = CW'(CAUSE_ACCESS);
                        faddr_d = pc_q;
                        state_d = S_DONE;
                    end else if (is_compressed(mem_rsp_data_i)) begin
                        kind_d  = RK_COMP;
                        instr_d = {{HW{1'b0}}, mem_rsp_data_i};
                        state_d = S_DONE;
                    end else if (!h_ok) begin
                        kind_d  = RK_HOOK;
                        cause_d = h_err;
                        faddr_d = pc_hi;
                        state_d = S_DONE;
                    end else begin
                        lo_d    = mem_rsp_data_i;
                        va_d    = h_use;
                        state_d = S_XLATE_HI;
                    end
                end
            end
            S_READ_HI: begin
                if (!sent_q) begin
                    sent_d = mem_req_ready_i;
                end else if (mem_rsp_valid_i) begin
                    sent_d  = 1'b0;
                    state_d = S_DONE;
                    if (mem_rsp_err_i) begin
                        kind_d  = RK_FAULT;
                        cause_d = CW'(CAUSE_ACCESS);
                        faddr_d = pc_hi;
                    end else begin
                        kind_d  = RK_FULL;
                        instr_d = {mem_rsp_data_i, lo_q};
                    end
                end
            end
            S_DONE:  state_d = S_IDLE;
            default: state_d = S_IDLE;
        endcase
    end

    // Outputs
    always_comb begin
        xl_req_valid_o  = ((state_q == S_XLATE_LO) || (state_q == S_XLATE_HI)) && !sent_q;
        xl_req_va_o     = va_q;
        mem_req_valid_o = ((state_q == S_READ_LO) || (state_q == S_READ_HI)) && !sent_q;
        mem_req_addr_o  = pa_q;
        done_o          = (state_q == S_DONE);
        kind_o          = kind_q;
        instr_o         = instr_q;
        cause_o         = cause_q;
        fault_addr_o    = faddr_q;
    end

    p_xl_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        xl_req_valid_o && !xl_req_ready_i |=> xl_req_valid_o && $stable(xl_req_va_o));
    p_mem_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req_valid_o && !mem_req_ready_i |=> mem_req_valid_o && $stable(mem_req_addr_o));
    p_one_port_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !(xl_req_valid_o && mem_req_valid_o));
    p_done_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);
    p_comp_shape_r5: assert property (@(posedge clk) disable iff (!rst_n)
        done_o && kind_o == RK_COMP |-> instr_o[1:0] != 2'b11 && instr_o[IW-1:HW] == '0);
    p_full_shape_r6: assert property (@(posedge clk) disable iff (!rst_n)
        done_o && kind_o == RK_FULL |-> instr_o[1:0] == 2'b11);
    p_hi_fault_addr_r7: assert property (@(posedge clk) disable iff (!rst_n)
        state_q == S_XLATE_HI && sent_q && xl_rsp_valid_i && xl_rsp_fault_i
        |=> done_o && fault_addr_o == $past(pc_q) + XLEN'(2));

endmodule

// File: tb/ifetch_seq_tb.sv
module ifetch_seq_tb;
    import ifetch_pkg::*;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start_i = 1'b0;
    logic [31:0] pc_i = '0;
    logic        rvc_en_i = 1'b0;
    logic [31:0] hook_pc_o;
    logic        hook_ok_i;
    logic [31:0] hook_use_i;
    logic [3:0]  hook_err_i;
    logic        xl_req_valid_o, xl_req_ready_i;
    logic [31:0] xl_req_va_o;
    logic        xl_rsp_valid_i, xl_rsp_fault_i;
    logic [3:0]  xl_rsp_cause_i;
    logic [31:0] xl_rsp_pa_i;
    logic        mem_req_valid_o, mem_req_ready_i;
    logic [31:0] mem_req_addr_o;
    logic        mem_rsp_valid_i, mem_rsp_err_i;
    logic [15:0] mem_rsp_data_i;
    logic        done_o;
    logic [1:0]  kind_o;
    logic [31:0] instr_o;
    logic [3:0]  cause_o;
    logic [31:0] fault_addr_o;

    always #2 clk = ~clk;

    ifetch_seq u_dut (.*);

    int n_chk = 0, n_fail = 0;
    int lat = 0, xl_n = 0, mem_n = 0;
    int xl_ph = 0, xl_cnt = 0, mem_ph = 0, mem_cnt = 0;
    logic [31:0] xl_va, mem_pa;
    logic [1:0]  r_kind;
    logic [31:0] r_instr, r_addr;
    logic [3:0]  r_cause;

    // Environment model
    function automatic logic [31:0] subst(input logic [31:0] a);
        return (a[31:24] == 8'h55) ? a + 32'h0000_1000 : a;
    endfunction
    function automatic logic xl_bad(input logic [31:0] va);
        return va[31:24] == 8'hFE || va[31:24] == 8'h56;
    endfunction
    function automatic logic [31:0] pa_of(input logic [31:0] va);
        return va ^ 32'h1000_0000;
    endfunction
    function automatic logic mem_bad(input logic [31:0] pa);
        return pa[31:24] == 8'hA0;
    endfunction
    function automatic logic [15:0] hw_at(input logic [31:0] pa);
        return {pa[13:0], pa[4] ? 2'b11 : 2'b01};
    endfunction
    function automatic logic [31:0] exp_instr(input logic [31:0] pc);
        logic [15:0] lo;
        lo = hw_at(pa_of(subst(pc)));
        if (lo[1:0] != 2'b11) return {16'h0, lo};
        return {hw_at(pa_of(subst(pc + 32'd2))), lo};
    endfunction

    always_comb begin
        hook_ok_i  = hook_pc_o[31:24] != 8'hCC;
        hook_err_i = 4'h9;
        hook_use_i = subst(hook_pc_o);
    end

    always @(negedge clk) begin
        if (!rst_n) begin
            xl_ph = 0; xl_cnt = 0; xl_req_ready_i <= 1'b0; xl_rsp_valid_i <= 1'b0;
            xl_rsp_fault_i <= 1'b0; xl_rsp_cause_i <= 4'hC; xl_rsp_pa_i <= '0;
        end else begin
            case (xl_ph)
                0: if (xl_req_valid_o) begin
                       if (xl_cnt == 0) begin xl_req_ready_i <= 1'b1; xl_va = xl_req_va_o; xl_ph = 1; end
                       else xl_cnt = xl_cnt - 1;
                   end
                1: begin xl_req_ready_i <= 1'b0; xl_n = xl_n + 1; xl_cnt = lat; xl_ph = 2; end
                2: if (xl_cnt == 0) begin
                       xl_rsp_valid_i <= 1'b1; xl_rsp_fault_i <= xl_bad(xl_va);
                       xl_rsp_pa_i <= pa_of(xl_va); xl_ph = 3;
                   end else xl_cnt = xl_cnt - 1;
                default: begin xl_rsp_valid_i <= 1'b0; xl_cnt = lat; xl_ph = 0; end
            endcase
        end
    end

    always @(negedge clk) begin
        if (!rst_n) begin
            mem_ph = 0; mem_cnt = 0; mem_req_ready_i <= 1'b0; mem_rsp_valid_i <= 1'b0;
            mem_rsp_err_i <= 1'b0; mem_rsp_data_i <= '0;
        end else begin
            case (mem_ph)
                0: if (mem_req_valid_o) begin
                       if (mem_cnt == 0) begin mem_req_ready_i <= 1'b1; mem_pa = mem_req_addr_o; mem_ph = 1; end
                       else mem_cnt = mem_cnt - 1;
                   end
                1: begin mem_req_ready_i <= 1'b0; mem_n = mem_n + 1; mem_cnt = lat; mem_ph = 2; end
                2: if (mem_cnt == 0) begin
                       mem_rsp_valid_i <= 1'b1; mem_rsp_err_i <= mem_bad(mem_pa);
                       mem_rsp_data_i <= hw_at(mem_pa); mem_ph = 3;
                   end else mem_cnt = mem_cnt - 1;
                default: begin mem_rsp_valid_i <= 1'b0; mem_cnt = lat; mem_ph = 0; end
            endcase
        end
    end

    task automatic check(input logic ok, input string tag, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    task automatic wait_done(input string tag);
        for (int i = 0; i < 400; i++) begin
            if (done_o) begin
                r_kind = kind_o; r_instr = instr_o; r_cause = cause_o; r_addr = fault_addr_o;
                return;
            end
            @(negedge clk);
        end
        check(1'b0, tag, "watchdog: no done", 32'h0, 32'h1);
        r_kind = 2'bx;
    endtask

    task automatic fetch(input logic [31:0] pc, input logic rvc, input int l, input string tag);
        @(negedge clk);
        lat = l; xl_n = 0; mem_n = 0;
        start_i = 1'b1; pc_i = pc; rvc_en_i = rvc;
        @(negedge clk);
        start_i = 1'b0;
        wait_done(tag);
    endtask

    // {pc, rvc, latency, kind, cause, fault address}
    localparam int NV = 14;
    localparam logic [73:0] VEC [NV] = '{
        {32'h0000_0020, 1'b1, 3'd0, 2'd0, 4'h0, 32'h0},
        {32'h0000_0012, 1'b1, 3'd1, 2'd1, 4'h0, 32'h0},
        {32'h0000_0011, 1'b1, 3'd0, 2'd2, 4'h0, 32'h0000_0011},
        {32'h0000_0012, 1'b0, 3'd2, 2'd2, 4'h0, 32'h0000_0012},
        {32'hFE00_0004, 1'b1, 3'd1, 2'd2, 4'hC, 32'hFE00_0004},
        {32'hB000_0010, 1'b1, 3'd2, 2'd2, 4'h1, 32'hB000_0010},
        {32'hFFFF_FFFE, 1'b1, 3'd3, 2'd1, 4'h0, 32'h0},
        {32'hFDFF_FFFE, 1'b1, 3'd0, 2'd2, 4'hC, 32'hFE00_0000},
        {32'hAFFF_FFFE, 1'b1, 3'd1, 2'd2, 4'h1, 32'hB000_0000},
        {32'hCC00_0010, 1'b1, 3'd0, 2'd3, 4'h9, 32'hCC00_0010},
        {32'hCBFF_FFFE, 1'b1, 3'd2, 2'd3, 4'h9, 32'hCC00_0000},
        {32'h5500_0030, 1'b1, 3'd1, 2'd1, 4'h0, 32'h0},
        {32'h55FF_F010, 1'b1, 3'd0, 2'd2, 4'hC, 32'h55FF_F010},
        {32'h0000_0106, 1'b1, 3'd3, 2'd0, 4'h0, 32'h0}
    };
    localparam string TAG [NV] = '{"R5", "R6", "R2", "R2", "R3", "R4", "R6",
                                   "R7", "R7", "R8", "R8", "R8", "R8", "R5"};

    initial begin
        #(4 * 150000);
        check(1'b0, "R9", "global watchdog expired", 32'h0, 32'h1);
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        // R1: reset state
        repeat (3) @(negedge clk);
        check(!done_o && !xl_req_valid_o && !mem_req_valid_o, "R1", "idle in reset",
              {29'b0, done_o, xl_req_valid_o, mem_req_valid_o}, 32'h0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        check(!done_o && !xl_req_valid_o && !mem_req_valid_o, "R1", "idle after reset",
              {29'b0, done_o, xl_req_valid_o, mem_req_valid_o}, 32'h0);

        for (int v = 0; v < NV; v++) begin
            logic [31:0] pc, fa;
            logic        rvc;
            logic [1:0]  k;
            logic [3:0]  c;
            int          l;
            pc  = VEC[v][73:42];
            rvc = VEC[v][41];
            l   = int'(VEC[v][40:38]);
            k   = VEC[v][37:36];
            c   = VEC[v][35:32];
            fa  = VEC[v][31:0];
            fetch(pc, rvc, l, TAG[v]);
            check(r_kind == k, TAG[v], "kind", {30'b0, r_kind}, {30'b0, k});
            if (k >= 2'd2) begin
                check(r_cause == c, TAG[v], "cause", {28'b0, r_cause}, {28'b0, c});
                check(r_addr == fa, TAG[v], "fault address", r_addr, fa);
            end else begin
                check(r_instr == exp_instr(pc), TAG[v], "instruction", r_instr, exp_instr(pc));
            end
            if (k == 2'd0)
                check(xl_n == 1 && mem_n == 1, "R5", "single granule traffic",
                      32'(xl_n * 16 + mem_n), 32'h11);
            if (k == 2'd1)
                check(xl_n == 2 && mem_n == 2, "R6", "two granule traffic",
                      32'(xl_n * 16 + mem_n), 32'h22);
            if (k == 2'd2 && c == 4'h0)
                check(xl_n == 0, "R2", "no translation on misalign", 32'(xl_n), 32'h0);
        end

        // R10: a start pulse during a fetch is ignored, and done lasts one cycle
        @(negedge clk);
        lat = 3; xl_n = 0; mem_n = 0;
        start_i = 1'b1; pc_i = 32'h0000_0012; rvc_en_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        repeat (2) @(negedge clk);
        start_i = 1'b1; pc_i = 32'h0000_0020;
        @(negedge clk);
        start_i = 1'b0;
        wait_done("R10");
        check(r_kind == 2'd1 && r_instr == exp_instr(32'h0000_0012), "R10",
              "busy start ignored", r_instr, exp_instr(32'h0000_0012));
        begin
            int extra;
            extra = 0;
            for (int i = 0; i < 12; i++) begin
                @(negedge clk);
                if (done_o) extra++;
            end
            check(extra == 0, "R10", "no second done", 32'(extra), 32'h0);
        end

        // R9: long latency on both ports still completes correctly
        fetch(32'h0000_0014, 1'b1, 7, "R9");
        check(r_kind == 2'd1 && r_instr == exp_instr(32'h0000_0014), "R9",
              "slow handshakes", r_instr, exp_instr(32'h0000_0014));

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule